// File: doc/BRIEF.md
# Two-World Split Permission Checker

This block guards an 8 KB fast memory window shared by two privilege worlds. Each world owns one split line that cuts the window into a lower and an upper area. Each of the four resulting (world, area) pairs carries its own read, write and execute grant bits. Every access that arrives with an address, an access kind and a world number gets a registered allow or deny one cycle later. Addresses outside the window are passed through unchecked.

A simple write port programs the block. It loads the two split lines, given as full byte addresses on a 4-byte grid, and the four 3-bit grant fields. It also sets a shared lock, which system software is expected to set once the whole setup is in place. After that the configuration is frozen until reset. Readback ports return both split lines, rebuilt as full addresses, together with the grant fields and the lock state.

Top module: `pmsf_top`

## Requirements
- R1: After a synchronous reset both split readbacks equal the window base, all twelve grant bits are 0, the lock is clear and no response is valid.
- R2: A split write (cfg_kind 0) for world 0 or 1 whose data is 4-byte aligned and lies at or above the base and below base + 8192 stores the line for that world only. Readback then returns that exact address, and the other world's line is unchanged.
- R3: A split write whose data is unaligned, below the base, or at or above base + 8192 is dropped, and both lines keep their values.
- R4: A split or grant write whose cfg_world is 2 or 3 is dropped and changes no state.
- R5: A grant write (cfg_kind 1) loads cfg_wdata[2:0] into the field of the selected world and area (cfg_high 0 means low, 1 means high), where bit 0 is read, bit 1 is write and bit 2 is execute. The other three fields keep their values. rd_perm packs the fields as [2:0] world 0 low, [5:3] world 0 high, [8:6] world 1 low, [11:9] world 1 high.
- R6: A lock write (cfg_kind 2) with cfg_wdata[0] = 1 sets cfg_locked. With cfg_wdata[0] = 0 it has no effect. cfg_kind 3 is a no-op.
- R7: While locked, every configuration write is ignored and the lock stays set until reset.
- R8: For an in-window access by world 0 or 1, an address below that world's split line uses the low-area field, and an address at or above it uses the high-area field.
- R9: An in-window access is allowed only if its kind's bit is set in the selected field (acc_kind 0 = read, 1 = write, 2 = execute). acc_kind 3 is always denied.
- R10: An access outside [base, base + 8192) gives resp_inrange = 0 and resp_allow = 1.
- R11: An in-window access with acc_world 2 or 3 is denied.
- R12: Responses appear exactly one clock after acc_valid, are computed from the configuration held before any write in the same cycle, and resp_valid, resp_inrange and resp_allow are all 0 in a cycle following no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | 0 split, 1 grant field, 2 lock, 3 none |
| cfg_world | input | 2 | Target world of a split or grant write |
| cfg_high | input | 1 | Grant write targets the upper area |
| cfg_wdata | input | ADDR_W | Split address, grant bits or lock bit |
| acc_valid | input | 1 | Access request present |
| acc_addr | input | ADDR_W | Access byte address |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| acc_world | input | 2 | World issuing the access |
| resp_valid | output | 1 | Registered response present |
| resp_inrange | output | 1 | Access hit the guarded window |
| resp_allow | output | 1 | Access permitted |
| rd_split_w0 | output | ADDR_W | World 0 split line as an address |
| rd_split_w1 | output | ADDR_W | World 1 split line as an address |
| rd_perm | output | 12 | Four packed grant fields |
| cfg_locked | output | 1 | Configuration lock state |

## Verification
The bench drives accesses at the edges of the split line: one word below it, on it, and one byte past the last word of the window. A design that compares with the wrong sense, or at byte rather than word granularity, then picks the wrong area and flips the verdict. The bench offers split addresses that are unaligned, one word below the base, and exactly at the window end, and it issues writes with worlds 2 and 3. A design that leaks any of these corrupts the readback. It also pairs a configuration write with an access in the same cycle and tries to unlock or reprogram a locked block. Here a wrongly forwarded write, or a lock that can be cleared, would show up as a verdict or readback change.

// File: rtl/pmsf_pkg.sv
package pmsf_pkg;

    localparam int NUM_WORLDS = 2;
    localparam int NUM_AREAS  = 2;
    localparam int NUM_FIELDS = NUM_WORLDS * NUM_AREAS;

    typedef enum logic [1:0] {
        CFG_SPLIT = 2'd0,
        CFG_PERM  = 2'd1,
        CFG_LOCK  = 2'd2,
        CFG_NONE  = 2'd3
    } cfg_kind_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

    typedef struct packed {
        logic valid;
        logic inrange;
        logic allow;
    } resp_t;

    function automatic logic perm_grants(perm_t p, acc_kind_e k);
        case (k)
            ACC_READ:  return p.r;
            ACC_WRITE: return p.w;
            ACC_FETCH: return p.x;
            default:   return 1'b0;
        endcase
    endfunction

    function automatic logic world_valid(logic [1:0] wid);
        return (wid[1] == 1'b0);
    endfunction

endpackage

// File: rtl/pmsf_cfg_regs.sv
module pmsf_cfg_regs
    import pmsf_pkg::*;
#(
    parameter int                ADDR_W       = 32,
    parameter logic [ADDR_W-1:0] REGION_BASE  = 32'h5000_0000,
    parameter int                REGION_BYTES = 8192,
    parameter int                GRAN_SH      = 2,
    parameter int                SPLIT_W      = 11
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           cfg_we,
    input  cfg_kind_e                      cfg_kind,
    input  logic [1:0]                     cfg_world,
    input  logic                           cfg_high,
    input  logic [ADDR_W-1:0]              cfg_wdata,
    output logic [NUM_WORLDS-1:0][SPLIT_W-1:0] split_q,
    output perm_t [NUM_FIELDS-1:0]         perm_q,
    output logic                           lock_q
);

    localparam logic [ADDR_W:0] REGION_END =
        {1'b0, REGION_BASE} + (ADDR_W+1)'(REGION_BYTES);

    logic               wr_open;
    logic               wid_ok;
    logic               in_window;
    logic               aligned;
    logic               split_ok;
    logic [SPLIT_W-1:0] split_field;

    always_comb begin
        wr_open     = cfg_we && !lock_q;
        wid_ok      = world_valid(cfg_world);
        in_window   = (cfg_wdata >= REGION_BASE) &&
                      ({1'b0, cfg_wdata} < REGION_END);
        aligned     = (cfg_wdata[GRAN_SH-1:0] == '0);
        split_ok    = wr_open && (cfg_kind == CFG_SPLIT) && wid_ok &&
                      in_window && aligned;
        split_field = SPLIT_W'((cfg_wdata - REGION_BASE) >> GRAN_SH);
    end

    for (genvar w = 0; w < NUM_WORLDS; w++) begin : g_split
        always_ff @(posedge clk) begin
            if (rst) begin
                split_q[w] <= '0;
            end else if (split_ok && (cfg_world[0] == 1'(w))) begin
                split_q[w] <= split_field;
            end
        end

        for (genvar a = 0; a < NUM_AREAS; a++) begin : g_area
            always_ff @(posedge clk) begin
                if (rst) begin
                    perm_q[w*NUM_AREAS+a] <= '0;
                end else if (wr_open && (cfg_kind == CFG_PERM) && wid_ok &&
                             (cfg_world[0] == 1'(w)) && (cfg_high == 1'(a))) begin
                    perm_q[w*NUM_AREAS+a] <= perm_t'(cfg_wdata[2:0]);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
        end else if (wr_open && (cfg_kind == CFG_LOCK) && cfg_wdata[0]) begin
            lock_q <= 1'b1;
        end
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> lock_q); // R7

    AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> ($stable(split_q) && $stable(perm_q))); // R7

    AST_UNALIGNED_SPLIT_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && (cfg_kind == CFG_SPLIT) && !aligned) |=> $stable(split_q)); // R3

    AST_BAD_WORLD_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_world[1] && (cfg_kind != CFG_LOCK))
            |=> ($stable(split_q) && $stable(perm_q))); // R4

endmodule

// File: rtl/pmsf_access_check.sv
module pmsf_access_check
    import pmsf_pkg::*;
#(
    parameter int                ADDR_W       = 32,
    parameter logic [ADDR_W-1:0] REGION_BASE  = 32'h5000_0000,
    parameter int                REGION_BYTES = 8192,
    parameter int                GRAN_SH      = 2,
    parameter int                SPLIT_W      = 11
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               acc_valid,
    input  logic [ADDR_W-1:0]                  acc_addr,
    input  acc_kind_e                          acc_kind,
    input  logic [1:0]                         acc_world,
    input  logic [NUM_WORLDS-1:0][SPLIT_W-1:0] split_q,
    input  perm_t [NUM_FIELDS-1:0]             perm_q,
    output resp_t                              resp_q
);

    localparam logic [ADDR_W:0] REGION_END =
        {1'b0, REGION_BASE} + (ADDR_W+1)'(REGION_BYTES);

    logic               in_window;
    logic [SPLIT_W-1:0] word_idx;
    logic               sel_world;
    logic               upper;
    perm_t              field;
    logic               allow_c;

    always_comb begin
        in_window = (acc_addr >= REGION_BASE) &&
                    ({1'b0, acc_addr} < REGION_END);
        word_idx  = SPLIT_W'((acc_addr - REGION_BASE) >> GRAN_SH);
        sel_world = acc_world[0];
        upper     = (word_idx >= split_q[sel_world]);
        field     = perm_q[{sel_world, upper}];
        if (!in_window) begin
            allow_c = 1'b1;
        end else begin
            allow_c = world_valid(acc_world) && perm_grants(field, acc_kind);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q <= '0;
        end else begin
            resp_q.valid   <= acc_valid;
            resp_q.inrange <= acc_valid && in_window;
            resp_q.allow   <= acc_valid && allow_c;
        end
    end

    AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> resp_q.valid); // R12

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> (!resp_q.valid && !resp_q.allow && !resp_q.inrange)); // R12

    AST_OUTSIDE_PASS: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !in_window) |=> (resp_q.allow && !resp_q.inrange)); // R10

    AST_BAD_WORLD_DENY: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && in_window && acc_world[1]) |=> !resp_q.allow); // R11

    AST_RSVD_DENY: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && in_window && (acc_kind == ACC_RSVD)) |=> !resp_q.allow); // R9

endmodule

// File: rtl/pmsf_top.sv
module pmsf_top
    import pmsf_pkg::*;
#(
    parameter int                ADDR_W       = 32,
    parameter logic [ADDR_W-1:0] REGION_BASE  = 32'h5000_0000,
    parameter int                REGION_BYTES = 8192,
    parameter int                SPLIT_GRAN   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_kind,
    input  logic [1:0]        cfg_world,
    input  logic              cfg_high,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_kind,
    input  logic [1:0]        acc_world,
    output logic              resp_valid,
    output logic              resp_inrange,
    output logic              resp_allow,
    output logic [ADDR_W-1:0] rd_split_w0,
    output logic [ADDR_W-1:0] rd_split_w1,
    output logic [11:0]       rd_perm,
    output logic              cfg_locked
);

    localparam int OFF_W   = $clog2(REGION_BYTES);
    localparam int GRAN_SH = $clog2(SPLIT_GRAN);
    localparam int SPLIT_W = OFF_W - GRAN_SH;

    logic [NUM_WORLDS-1:0][SPLIT_W-1:0] split_q;
    perm_t [NUM_FIELDS-1:0]             perm_q;
    logic                               lock_q;
    resp_t                              resp_q;

    pmsf_cfg_regs #(
        .ADDR_W       (ADDR_W),
        .REGION_BASE  (REGION_BASE),
        .REGION_BYTES (REGION_BYTES),
        .GRAN_SH      (GRAN_SH),
        .SPLIT_W      (SPLIT_W)
    ) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_kind  (cfg_kind_e'(cfg_kind)),
        .cfg_world (cfg_world),
        .cfg_high  (cfg_high),
        .cfg_wdata (cfg_wdata),
        .split_q   (split_q),
        .perm_q    (perm_q),
        .lock_q    (lock_q)
    );

    pmsf_access_check #(
        .ADDR_W       (ADDR_W),
        .REGION_BASE  (REGION_BASE),
        .REGION_BYTES (REGION_BYTES),
        .GRAN_SH      (GRAN_SH),
        .SPLIT_W      (SPLIT_W)
    ) u_chk (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .acc_kind  (acc_kind_e'(acc_kind)),
        .acc_world (acc_world),
        .split_q   (split_q),
        .perm_q    (perm_q),
        .resp_q    (resp_q)
    );

    always_comb begin
        resp_valid   = resp_q.valid;
        resp_inrange = resp_q.inrange;
        resp_allow   = resp_q.allow;
        rd_split_w0  = REGION_BASE + (ADDR_W'(split_q[0]) << GRAN_SH);
        rd_split_w1  = REGION_BASE + (ADDR_W'(split_q[1]) << GRAN_SH);
        rd_perm      = perm_q;
        cfg_locked   = lock_q;
    end

    AST_READBACK_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (rd_split_w0 >= REGION_BASE) && (rd_split_w1 >= REGION_BASE)); // R2

endmodule

// File: tb/tb_pmsf_top.sv
module tb_pmsf_top;

    localparam logic [31:0] BASE = 32'h5000_0000;
    localparam logic [31:0] SIZE = 32'd8192;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_kind = 2'd3;
    logic [1:0]  cfg_world = 2'd0;
    logic        cfg_high = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_kind = 2'd0;
    logic [1:0]  acc_world = 2'd0;
    logic        resp_valid, resp_inrange, resp_allow, cfg_locked;
    logic [31:0] rd_split_w0, rd_split_w1;
    logic [11:0] rd_perm;

    int total = 0;
    int fails = 0;

    // behavioural reference state
    logic [31:0] m_split [2];
    logic [2:0]  m_perm  [4];
    logic        m_lock;
    logic        e_valid, e_inrange, e_allow;

    always #10 clk = ~clk;

    pmsf_top dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_world(cfg_world), .cfg_high(cfg_high), .cfg_wdata(cfg_wdata),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_kind(acc_kind),
        .acc_world(acc_world), .resp_valid(resp_valid),
        .resp_inrange(resp_inrange), .resp_allow(resp_allow),
        .rd_split_w0(rd_split_w0), .rd_split_w1(rd_split_w1),
        .rd_perm(rd_perm), .cfg_locked(cfg_locked)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_step();
        logic in_w;
        logic [2:0] p;
        int idx;
        if (rst) begin
            e_valid = 0; e_inrange = 0; e_allow = 0;
            m_split[0] = BASE; m_split[1] = BASE;
            for (int i = 0; i < 4; i++) m_perm[i] = 3'b000;
            m_lock = 0;
            return;
        end
        in_w = (acc_addr >= BASE) && (acc_addr < BASE + SIZE);
        e_valid = acc_valid;
        e_inrange = acc_valid && in_w;
        if (!acc_valid) e_allow = 0;
        else if (!in_w) e_allow = 1;
        else if (acc_world > 1) e_allow = 0;
        else begin
            idx = acc_world * 2 + ((acc_addr < m_split[acc_world]) ? 0 : 1);
            p = m_perm[idx];
            case (acc_kind)
                2'd0: e_allow = p[0];
                2'd1: e_allow = p[1];
                2'd2: e_allow = p[2];
                default: e_allow = 0;
            endcase
        end
        if (cfg_we && !m_lock) begin
            if (cfg_kind == 2'd0 && cfg_world < 2 && cfg_wdata % 4 == 0 &&
                cfg_wdata >= BASE && cfg_wdata < BASE + SIZE)
                m_split[cfg_world] = cfg_wdata;
            else if (cfg_kind == 2'd1 && cfg_world < 2)
                m_perm[cfg_world * 2 + int'(cfg_high)] = cfg_wdata[2:0];
            else if (cfg_kind == 2'd2 && cfg_wdata[0])
                m_lock = 1;
        end
    endtask

    task automatic tick(input string tag);
        model_step();
        @(negedge clk);
        chk(tag, "resp_valid",   32'(resp_valid),   32'(e_valid));
        chk(tag, "resp_inrange", 32'(resp_inrange), 32'(e_inrange));
        chk(tag, "resp_allow",   32'(resp_allow),   32'(e_allow));
        chk(tag, "rd_split_w0",  rd_split_w0, m_split[0]);
        chk(tag, "rd_split_w1",  rd_split_w1, m_split[1]);
        chk(tag, "rd_perm", 32'(rd_perm),
            32'({m_perm[3], m_perm[2], m_perm[1], m_perm[0]}));
        chk(tag, "cfg_locked",   32'(cfg_locked),   32'(m_lock));
    endtask

    task automatic cfg(input logic [1:0] k, input logic [1:0] w, input logic h,
                       input logic [31:0] d, input string tag);
        cfg_we = 1; cfg_kind = k; cfg_world = w; cfg_high = h; cfg_wdata = d;
        tick(tag);
        cfg_we = 0; cfg_kind = 2'd3;
    endtask

    task automatic acc(input logic [31:0] a, input logic [1:0] w,
                       input logic [1:0] k, input string tag);
        acc_valid = 1; acc_addr = a; acc_world = w; acc_kind = k;
        tick(tag);
        acc_valid = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL R12 watchdog expired: actual hang expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] pts [8];
        string t;
        pts = '{BASE, BASE + 32'hFC, BASE + 32'h100, BASE + 32'h1FF8,
                BASE + 32'h1FFC, BASE + 32'h1FFF, BASE + SIZE, BASE - 32'd1};

        // R1: reset state
        rst = 1;
        repeat (3) tick("R1");
        rst = 0;
        tick("R1");

        // R9 with all grants clear, R10 outside window
        acc(BASE + 32'h40, 2'd0, 2'd0, "R9");
        acc(BASE - 32'd4, 2'd0, 2'd0, "R10");
        acc(BASE + SIZE + 32'h10, 2'd1, 2'd3, "R10");

        // R5: four distinct grant fields
        cfg(2'd1, 2'd0, 1'b0, 32'h1, "R5");
        cfg(2'd1, 2'd0, 1'b1, 32'h6, "R5");
        cfg(2'd1, 2'd1, 1'b0, 32'h4, "R5");
        cfg(2'd1, 2'd1, 1'b1, 32'hFFFF_FFFB, "R5");

        // R2: split lines, per world, last legal word
        cfg(2'd0, 2'd0, 1'b0, BASE + 32'h100, "R2");
        cfg(2'd0, 2'd1, 1'b0, BASE + 32'h1FFC, "R2");

        // R3: rejected split values
        cfg(2'd0, 2'd0, 1'b0, BASE + 32'h102, "R3");
        cfg(2'd0, 2'd1, 1'b0, BASE - 32'd4, "R3");
        cfg(2'd0, 2'd0, 1'b0, BASE + SIZE, "R3");

        // R4: invalid world on split and grant writes
        cfg(2'd0, 2'd2, 1'b0, BASE + 32'h200, "R4");
        cfg(2'd1, 2'd3, 1'b1, 32'h7, "R4");
        cfg(2'd1, 2'd2, 1'b0, 32'h0, "R4");

        // R8/R9/R10/R11: sweep of boundaries, worlds and kinds
        for (int i = 0; i < 8; i++) begin
            for (int w = 0; w < 3; w++) begin
                for (int k = 0; k < 4; k++) begin
                    if (pts[i] < BASE || pts[i] >= BASE + SIZE) t = "R10";
                    else if (w == 2) t = "R11";
                    else if (k == 3) t = "R9";
                    else t = "R8";
                    acc(pts[i], 2'(w), 2'(k), t);
                end
            end
        end
        acc(BASE + 32'h20, 2'd3, 2'd0, "R11");

        // R12: back-to-back requests and write-with-access ordering
        acc_valid = 1; acc_addr = BASE + 32'h10; acc_world = 0; acc_kind = 0;
        tick("R12");
        cfg_we = 1; cfg_kind = 2'd1; cfg_world = 0; cfg_high = 0; cfg_wdata = 32'h0;
        tick("R12");
        cfg_we = 0; cfg_kind = 2'd3;
        tick("R12");
        acc_valid = 0;
        tick("R12");

        // R6: lock write with bit 0 clear, then no-op kind, then real lock
        cfg(2'd2, 2'd0, 1'b0, 32'hFFFF_FFFE, "R6");
        cfg(2'd3, 2'd0, 1'b0, 32'hFFFF_FFFF, "R6");
        cfg(2'd1, 2'd0, 1'b0, 32'h3, "R6");
        cfg(2'd2, 2'd0, 1'b0, 32'h1, "R6");

        // R7: writes ignored while locked
        cfg(2'd0, 2'd0, 1'b0, BASE + 32'h800, "R7");
        cfg(2'd1, 2'd1, 1'b1, 32'h0, "R7");
        cfg(2'd2, 2'd0, 1'b0, 32'h0, "R7");
        acc(BASE + 32'h10, 2'd0, 2'd1, "R7");
        acc(BASE + 32'h1FFC, 2'd1, 2'd1, "R7");

        // R1: reset clears lock and setup
        rst = 1;
        tick("R1");
        rst = 0;
        tick("R1");
        acc(BASE + 32'h1FFC, 2'd1, 2'd0, "R1");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule